// File: doc/BRIEF.md
# J-K Register Bank with Initialization and Diagnostic Access

This block is the register core of a programmable sequencer. It holds a state register, whose bits feed back to an external logic array, and an output register, whose bits drive the pad port. Both are made of J-K flip-flops. The external array computes the J and K vectors. The block applies them on the rising edge of the clock that owns each bit.

A single control pin serves one of two purposes, chosen by a configuration bit. In the first use it is an asynchronous initialize that loads a per-bit preset or reset pattern into both registers. In the second use it is an active-low enable for the pad drivers. A second clock can take over the upper half of both registers, which splits the block into two independently clocked halves.

Three diagnostic selects are provided. The first makes the pads show the state register. The second loads the state register from the pads. The third loads the output register from the pads. The bidirectional pad port is modelled as separate in, out and enable signals.

Top module: `jk_diag_regbank`

## Requirements
- R1: While `rst_n` is low, each rising edge of a bit's domain clock sets that bit of both registers to 1, whatever initialization patterns are configured.
- R2: In normal operation, on each rising edge of its domain clock, every register bit follows its J/K pair: J=0,K=0 holds, J=1,K=0 sets, J=0,K=1 clears, J=1,K=1 toggles.
- R3: With `cfg_pin_is_init`=1, a high `init_oe_pin` immediately loads `cfg_init_state` into the state register and `cfg_init_out` into the output register, where a pattern bit of 1 presets and 0 resets. The bits keep those values for as long as the pin stays high, whatever happens on the clocks.
- R4: After the initialize pin falls, or after reset is released, a domain updates only on a rising edge that comes after at least one falling edge of its clock. A rising edge with no falling edge before it leaves the registers unchanged.
- R5: With `cfg_pin_is_init`=0, the pin is an active-low driver enable: `f_oe` is 0 while the pin is high, and the pin never initializes anything. With `cfg_pin_is_init`=1, `f_oe` is 1 outside the load modes.
- R6: With `cfg_split_clk`=1, `clk1` updates bits 3:0 of both registers and `clk2` updates bits 7:4. With `cfg_split_clk`=0, `clk1` updates all bits and `clk2` has no effect.
- R7: In observe mode, `f_out` shows the state register. The state register still follows J/K, and the output register holds its contents.
- R8: In state-load mode, `f_oe` is 0, a rising edge loads `f_in` into the state register, and the output register holds.
- R9: In output-load mode, `f_oe` is 0, a rising edge loads `f_in` into the output register, and the state register holds.
- R10: When more than one select is high, state-load wins over output-load, and output-load wins over observe. When no select is high, `f_out` shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk1 | input | 1 | Main clock; clocks all bits, or only the lower half when split |
| clk2 | input | 1 | Second clock for the upper half when split is enabled |
| rst_n | input | 1 | Synchronous active-low power-up preset to all ones |
| cfg_pin_is_init | input | 1 | 1: control pin is initialize; 0: control pin is active-low driver enable |
| cfg_split_clk | input | 1 | 1: upper half of both registers is clocked by clk2 |
| cfg_init_state | input | 8 | Per-bit initialization value of the state register |
| cfg_init_out | input | 8 | Per-bit initialization value of the output register |
| init_oe_pin | input | 1 | Shared initialize / output-enable pin |
| diag_observe | input | 1 | Select: pads show the state register |
| diag_load_state | input | 1 | Select: pads load the state register |
| diag_load_out | input | 1 | Select: pads load the output register |
| state_j | input | 8 | J inputs of the state register |
| state_k | input | 8 | K inputs of the state register |
| out_j | input | 8 | J inputs of the output register |
| out_k | input | 8 | K inputs of the output register |
| state_q | output | 8 | State register, fed back to the logic array |
| f_in | input | 8 | Values forced on the pads |
| f_out | output | 8 | Value the pad drivers present |
| f_oe | output | 1 | Pad driver enable |

## Verification
The clocked properties assume three things about the inputs. Every input other than a clock changes only away from the clock edges. The initialization patterns stay constant while the initialize pin is high. The split setting changes only while both clocks are low, so that the clock multiplexer cannot create an edge. The stimulus meets these assumptions. It changes data one time unit after a rising `clk1` edge. It changes the split bit just after a falling edge, with `clk2` parked low. It pulses `clk2` only in the middle of a `clk1` period. The single exception is the release of the initialize pin, which is placed while `clk1` is low so that the resume rule can be seen.

// File: rtl/jk_diag_regbank_pkg.sv
// Package: shared types and helpers for the J-K register bank.
// Assumes nothing beyond the J-K characteristic equation.
package jk_diag_regbank_pkg;

    // Diagnostic mode after priority resolution.
    typedef enum logic [1:0] {
        DM_NORMAL     = 2'd0,
        DM_OBSERVE    = 2'd1,
        DM_LOAD_OUT   = 2'd2,
        DM_LOAD_STATE = 2'd3
    } diag_mode_e;

    // Next value of a vector of J-K flip-flops.
    function automatic logic [7:0] jk_next8(input logic [7:0] j,
                                            input logic [7:0] k,
                                            input logic [7:0] q);
        return (j & ~q) | (~k & q);
    endfunction

endpackage

// File: rtl/jk_diag_mode_decode.sv
// Module: jk_diag_mode_decode
// Resolves the three diagnostic selects into a single mode, using the
// priority state-load > output-load > observe. It also chooses the pad data
// and the pad driver enable.
// Assumes: pins_enabled already combines the configured pin function with
// the pin level. clk and rst_n serve only the local assertions.
module jk_diag_mode_decode
    import jk_diag_regbank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         diag_observe,
    input  logic         diag_load_state,
    input  logic         diag_load_out,
    input  logic         pins_enabled,
    input  logic [W-1:0] state_q,
    input  logic [W-1:0] out_q,
    output diag_mode_e   mode,
    output logic [W-1:0] f_out,
    output logic         f_oe
);

    // Priority resolution of the diagnostic selects.
    always_comb begin
        if (diag_load_state)    mode = DM_LOAD_STATE;
        else if (diag_load_out) mode = DM_LOAD_OUT;
        else if (diag_observe)  mode = DM_OBSERVE;
        else                    mode = DM_NORMAL;
    end

    // Pad data: the state register in observe mode, the output register otherwise.
    always_comb begin
        f_out = (mode == DM_OBSERVE) ? state_q : out_q;
    end

    // Pad drivers: off in either load mode, otherwise follow the enable.
    always_comb begin
        f_oe = pins_enabled && (mode != DM_LOAD_STATE) && (mode != DM_LOAD_OUT);
    end

    // R8/R9: the pads are inputs whenever a load select is raised.
    a_r8_pads_released_for_load: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_load_state || diag_load_out) |-> !f_oe);

endmodule

// File: rtl/jk_diag_resume_gate.sv
// Module: jk_diag_resume_gate
// Produces the "armed" flag of one clock domain. An active initialize clears
// the flag asynchronously, and reset clears it on a falling edge. The first
// falling clock edge with both released sets it. Rising edges update the
// registers only while the flag is set.
// Assumes: init_act is free of glitches.
module jk_diag_resume_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic init_act,
    output logic armed
);

    // Arm on a falling edge once initialize and reset are both released.
    always_ff @(negedge clk or posedge init_act) begin
        if (init_act)    armed <= 1'b0;
        else if (!rst_n) armed <= 1'b0;
        else             armed <= 1'b1;
    end

endmodule

// File: rtl/jk_diag_jk_reg.sv
// Module: jk_diag_jk_reg
// A vector of J-K flip-flops. It has an asynchronous load of a per-bit
// initialization pattern, a synchronous active-low preset to all ones, a
// parallel load path, and a hold control.
// Assumes: load_en and hold are never high together, and updates happen
// only while armed is set.
module jk_diag_jk_reg
    import jk_diag_regbank_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_act,
    input  logic         armed,
    input  logic [W-1:0] init_pat,
    input  logic         load_en,
    input  logic         hold,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] j,
    input  logic [W-1:0] k,
    output logic [W-1:0] q
);

    localparam int PAD = 8 - W;

    logic [7:0]   nxt8;
    logic [W-1:0] nxt;

    // J-K next value, computed on a padded 8-bit vector.
    always_comb begin
        nxt8 = jk_next8({{PAD{1'b0}}, j}, {{PAD{1'b0}}, k}, {{PAD{1'b0}}, q});
        nxt  = nxt8[W-1:0];
    end

    // Register update: initialize, then preset, then load, hold or J-K.
    always_ff @(posedge clk or posedge init_act) begin
        if (init_act) begin
            q <= init_pat;
        end else if (!rst_n) begin
            q <= '1;
        end else if (armed) begin
            if (load_en)   q <= load_val;
            else if (!hold) q <= nxt;
        end
    end

    // R1: a reset edge leaves every bit at one.
    a_r1_reset_ones: assert property (@(posedge clk) disable iff (init_act)
        !rst_n |=> (q == '1));

    // R3: while initialize is high, the bits carry the configured pattern.
    a_r3_init_forces: assert property (@(posedge clk)
        init_act |-> (q == init_pat));

    // R4: a rising edge without a falling edge before it changes nothing.
    a_r4_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n || init_act)
        !armed |=> (q == $past(q)));

    // R8/R9: a load edge captures the pad value.
    a_r9_load_captures: assert property (@(posedge clk) disable iff (!rst_n || init_act)
        (armed && load_en) |=> (q == $past(load_val)));

    // R7/R8/R9: a register on hold keeps its contents.
    a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n || init_act)
        (armed && hold && !load_en) |=> $stable(q));

endmodule

// File: rtl/jk_diag_slice.sv
// Module: jk_diag_slice
// One clock-domain slice: a group of state bits and output bits, their clock
// choice and their resume gate. USE_CLK2 marks a slice that moves to clk2
// when the split is enabled.
// Assumes: split_en changes only while both clocks are low.
module jk_diag_slice
    import jk_diag_regbank_pkg::*;
#(
    parameter int W        = 4,
    parameter bit USE_CLK2 = 1'b0
) (
    input  logic         clk1,
    input  logic         clk2,
    input  logic         split_en,
    input  logic         rst_n,
    input  logic         init_act,
    input  diag_mode_e   mode,
    input  logic [W-1:0] init_state_pat,
    input  logic [W-1:0] init_out_pat,
    input  logic [W-1:0] state_j,
    input  logic [W-1:0] state_k,
    input  logic [W-1:0] out_j,
    input  logic [W-1:0] out_k,
    input  logic [W-1:0] f_in,
    output logic [W-1:0] state_q,
    output logic [W-1:0] out_q
);

    logic dom_clk;
    logic armed;
    logic st_load, st_hold, op_load, op_hold;

    // Domain clock: clk2 only for an upper slice with the split enabled.
    always_comb begin
        dom_clk = (USE_CLK2 && split_en) ? clk2 : clk1;
    end

    // Mode to per-register load and hold controls.
    always_comb begin
        st_load = (mode == DM_LOAD_STATE);
        st_hold = (mode == DM_LOAD_OUT);
        op_load = (mode == DM_LOAD_OUT);
        op_hold = (mode == DM_OBSERVE) || (mode == DM_LOAD_STATE);
    end

    jk_diag_resume_gate u_gate (
        .clk      (dom_clk),
        .rst_n    (rst_n),
        .init_act (init_act),
        .armed    (armed)
    );

    jk_diag_jk_reg #(.W(W)) u_state (
        .clk      (dom_clk),
        .rst_n    (rst_n),
        .init_act (init_act),
        .armed    (armed),
        .init_pat (init_state_pat),
        .load_en  (st_load),
        .hold     (st_hold),
        .load_val (f_in),
        .j        (state_j),
        .k        (state_k),
        .q        (state_q)
    );

    jk_diag_jk_reg #(.W(W)) u_out (
        .clk      (dom_clk),
        .rst_n    (rst_n),
        .init_act (init_act),
        .armed    (armed),
        .init_pat (init_out_pat),
        .load_en  (op_load),
        .hold     (op_hold),
        .load_val (f_in),
        .j        (out_j),
        .k        (out_k),
        .q        (out_q)
    );

endmodule

// File: rtl/jk_diag_regbank.sv
// Module: jk_diag_regbank
// Top level of the J-K register bank. It interprets the shared control pin,
// builds one slice per clock group, and decodes the diagnostic selects.
// Assumes: REG_W is a multiple of SLICE_W. Slices in the upper half move to
// clk2 when the split is enabled.
module jk_diag_regbank
    import jk_diag_regbank_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int SLICE_W = 4
) (
    input  logic             clk1,
    input  logic             clk2,
    input  logic             rst_n,
    input  logic             cfg_pin_is_init,
    input  logic             cfg_split_clk,
    input  logic [REG_W-1:0] cfg_init_state,
    input  logic [REG_W-1:0] cfg_init_out,
    input  logic             init_oe_pin,
    input  logic             diag_observe,
    input  logic             diag_load_state,
    input  logic             diag_load_out,
    input  logic [REG_W-1:0] state_j,
    input  logic [REG_W-1:0] state_k,
    input  logic [REG_W-1:0] out_j,
    input  logic [REG_W-1:0] out_k,
    output logic [REG_W-1:0] state_q,
    input  logic [REG_W-1:0] f_in,
    output logic [REG_W-1:0] f_out,
    output logic             f_oe
);

    localparam int N_SLICES   = REG_W / SLICE_W;
    localparam int FIRST_CLK2 = N_SLICES / 2;

    logic             init_act;
    logic             pins_enabled;
    logic [REG_W-1:0] out_q;
    diag_mode_e       mode;

    // Shared pin: initialize when so configured, else active-low enable.
    always_comb begin
        init_act     = cfg_pin_is_init && init_oe_pin;
        pins_enabled = cfg_pin_is_init || !init_oe_pin;
    end

    jk_diag_mode_decode #(.W(REG_W)) u_decode (
        .clk             (clk1),
        .rst_n           (rst_n),
        .diag_observe    (diag_observe),
        .diag_load_state (diag_load_state),
        .diag_load_out   (diag_load_out),
        .pins_enabled    (pins_enabled),
        .state_q         (state_q),
        .out_q           (out_q),
        .mode            (mode),
        .f_out           (f_out),
        .f_oe            (f_oe)
    );

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        jk_diag_slice #(
            .W        (SLICE_W),
            .USE_CLK2 (s >= FIRST_CLK2)
        ) u_slice (
            .clk1           (clk1),
            .clk2           (clk2),
            .split_en       (cfg_split_clk),
            .rst_n          (rst_n),
            .init_act       (init_act),
            .mode           (mode),
            .init_state_pat (cfg_init_state[s*SLICE_W +: SLICE_W]),
            .init_out_pat   (cfg_init_out[s*SLICE_W +: SLICE_W]),
            .state_j        (state_j[s*SLICE_W +: SLICE_W]),
            .state_k        (state_k[s*SLICE_W +: SLICE_W]),
            .out_j          (out_j[s*SLICE_W +: SLICE_W]),
            .out_k          (out_k[s*SLICE_W +: SLICE_W]),
            .f_in           (f_in[s*SLICE_W +: SLICE_W]),
            .state_q        (state_q[s*SLICE_W +: SLICE_W]),
            .out_q          (out_q[s*SLICE_W +: SLICE_W])
        );
    end

    // R5: in enable mode, a high pin turns the pad drivers off.
    a_r5_enable_pin_low_active: assert property (@(posedge clk1) disable iff (!rst_n)
        (!cfg_pin_is_init && init_oe_pin) |-> !f_oe);

endmodule

// File: tb/jk_diag_regbank_tb.sv
// Directed bench for jk_diag_regbank. Each scenario task checks its own results.
module jk_diag_regbank_tb;

    logic       clk1 = 1'b0;
    logic       clk2 = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pin_is_init = 1'b1;
    logic       cfg_split_clk = 1'b0;
    logic [7:0] cfg_init_state = 8'hA5;
    logic [7:0] cfg_init_out = 8'h3C;
    logic       init_oe_pin = 1'b0;
    logic       diag_observe = 1'b0;
    logic       diag_load_state = 1'b0;
    logic       diag_load_out = 1'b0;
    logic [7:0] state_j = 8'h00, state_k = 8'h00;
    logic [7:0] out_j = 8'h00, out_k = 8'h00;
    logic [7:0] f_in = 8'h00;
    logic [7:0] state_q, f_out;
    logic       f_oe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk1 = ~clk1;   // 125 MHz

    jk_diag_regbank u_dut (
        .clk1            (clk1),
        .clk2            (clk2),
        .rst_n           (rst_n),
        .cfg_pin_is_init (cfg_pin_is_init),
        .cfg_split_clk   (cfg_split_clk),
        .cfg_init_state  (cfg_init_state),
        .cfg_init_out    (cfg_init_out),
        .init_oe_pin     (init_oe_pin),
        .diag_observe    (diag_observe),
        .diag_load_state (diag_load_state),
        .diag_load_out   (diag_load_out),
        .state_j         (state_j),
        .state_k         (state_k),
        .out_j           (out_j),
        .out_k           (out_k),
        .state_q         (state_q),
        .f_in            (f_in),
        .f_out           (f_out),
        .f_oe            (f_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance to one time unit after the next rising clk1 edge.
    task automatic tick();
        @(posedge clk1);
        #1;
    endtask

    task automatic quiet_jk();
        state_j = 8'h00; state_k = 8'h00; out_j = 8'h00; out_k = 8'h00;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check("R1", "state after reset", state_q, 8'hFF);
        check("R1", "output after reset", f_out, 8'hFF);
        check("R5", "drivers on in init mode", {7'd0, f_oe}, 8'h01);
        rst_n = 1'b1;
    endtask

    task automatic t_jk();
        state_k = 8'h0F;
        out_j = 8'hFF; out_k = 8'hFF;
        tick();
        check("R2", "clear low nibble", state_q, 8'hF0);
        check("R2", "toggle output", f_out, 8'h00);
        state_j = 8'h3C; state_k = 8'h5A;
        out_j = 8'h0F; out_k = 8'h00;
        tick();
        check("R2", "mixed hold/set/clear/toggle", state_q, 8'hAC);
        check("R2", "output set", f_out, 8'h0F);
        quiet_jk();
    endtask

    task automatic t_init_hold();
        init_oe_pin = 1'b1;
        #1;
        check("R3", "state pattern", state_q, 8'hA5);
        check("R3", "output pattern", f_out, 8'h3C);
        state_j = 8'hFF; state_k = 8'hFF; out_j = 8'hFF; out_k = 8'hFF;
        tick(); tick();
        check("R3", "state held under clocks", state_q, 8'hA5);
        check("R3", "output held under clocks", f_out, 8'h3C);
    endtask

    task automatic t_resume();
        @(posedge clk1);
        #5;                     // clk1 low: release after the falling edge
        init_oe_pin = 1'b0;
        tick();
        check("R4", "no update before a falling edge", state_q, 8'hA5);
        tick();
        check("R4", "update after falling edge", state_q, 8'h5A);
        check("R4", "output update after falling edge", f_out, 8'hC3);
        quiet_jk();
    endtask

    task automatic t_oe_mode();
        cfg_pin_is_init = 1'b0;
        #1;
        init_oe_pin = 1'b1;
        #1;
        check("R5", "drivers off with pin high", {7'd0, f_oe}, 8'h00);
        check("R5", "no initialize in enable mode", state_q, 8'h5A);
        state_j = 8'hFF; state_k = 8'hFF;
        tick();
        check("R5", "clocking continues", state_q, 8'hA5);
        quiet_jk();
        init_oe_pin = 1'b0;
        #1;
        check("R5", "drivers on with pin low", {7'd0, f_oe}, 8'h01);
        check("R5", "output register shown", f_out, 8'hC3);
        cfg_pin_is_init = 1'b1;
    endtask

    task automatic t_split();
        tick();
        state_j = 8'hFF; state_k = 8'hFF;
        @(negedge clk1);
        #1;
        cfg_split_clk = 1'b1;
        tick();
        check("R6", "clk1 toggles low half only", state_q, 8'hAA);
        #1 clk2 = 1'b1;
        #1;
        check("R6", "clk2 toggles high half", state_q, 8'h5A);
        clk2 = 1'b0;
        quiet_jk();
        @(negedge clk1);
        #1;
        cfg_split_clk = 1'b0;
        tick();
        state_j = 8'hFF; state_k = 8'hFF;
        #1 clk2 = 1'b1;
        #1;
        check("R6", "clk2 ignored when not split", state_q, 8'h5A);
        clk2 = 1'b0;
        tick();
        check("R6", "clk1 clocks all bits", state_q, 8'hA5);
        quiet_jk();
    endtask

    task automatic t_observe();
        diag_observe = 1'b1;
        state_j = 8'hFF;
        out_j = 8'hFF; out_k = 8'hFF;
        #1;
        check("R7", "pads show state", f_out, 8'hA5);
        tick();
        check("R7", "state follows J/K", f_out, 8'hFF);
        diag_observe = 1'b0;
        quiet_jk();
        #1;
        check("R7", "output register kept", f_out, 8'hC3);
    endtask

    task automatic t_load_state();
        diag_load_state = 1'b1;
        f_in = 8'h96;
        out_j = 8'hFF; out_k = 8'hFF;
        #1;
        check("R8", "drivers off", {7'd0, f_oe}, 8'h00);
        tick();
        check("R8", "state loaded", state_q, 8'h96);
        diag_load_state = 1'b0;
        quiet_jk();
        #1;
        check("R8", "output register kept", f_out, 8'hC3);
    endtask

    task automatic t_load_out();
        diag_load_out = 1'b1;
        f_in = 8'h4B;
        state_j = 8'hFF; state_k = 8'hFF;
        #1;
        check("R9", "drivers off", {7'd0, f_oe}, 8'h00);
        tick();
        diag_load_out = 1'b0;
        quiet_jk();
        #1;
        check("R9", "output loaded", f_out, 8'h4B);
        check("R9", "state kept", state_q, 8'h96);
    endtask

    task automatic t_priority();
        diag_observe = 1'b1; diag_load_state = 1'b1; diag_load_out = 1'b1;
        f_in = 8'hE1;
        out_j = 8'hFF; out_k = 8'hFF;
        tick();
        check("R10", "state-load wins", state_q, 8'hE1);
        diag_load_state = 1'b0;
        quiet_jk();
        f_in = 8'h1E;
        state_j = 8'hFF; state_k = 8'hFF;
        #1;
        check("R10", "output-load over observe: drivers off", {7'd0, f_oe}, 8'h00);
        tick();
        diag_observe = 1'b0; diag_load_out = 1'b0;
        quiet_jk();
        #1;
        check("R10", "output loaded over observe", f_out, 8'h1E);
        check("R10", "state held in output-load", state_q, 8'hE1);
    endtask

    initial begin
        t_reset();
        t_jk();
        t_init_hold();
        t_resume();
        t_oe_mode();
        t_split();
        t_observe();
        t_load_state();
        t_load_out();
        t_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk1);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule